// File: doc/BRIEF.md
# Dual 8-bit Reload Timer with Waveform Outputs

This block holds two independent 8-bit up-counters, a primary and a secondary, advanced by a shared clock-enable tick. Each counter has a count byte, a reload byte and a compare byte. When it passes 0xFF it restarts from its reload byte. Each counter drives a toggle waveform onto its own pad. That waveform flips on every compare match and on every wrap. An enable bit and a polarity bit shape each pad.

Only the primary counter has two extra features. It can be stalled by an external gate pin, and it can be fired once under software control with a single-shot bit. Software works through a plain register port. A write is taken on the clock edge when `wr_en` is high. Reads are combinational from `rd_addr`. The block has no data stream, so none of its ports use a valid/ready handshake. All ports are plain control and status signals. The gate pin is expected to be synchronous to `clk`.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, every register byte, both counts, all four flags and all four pad signals read 0.
- R2: A counter advances by one on each clock with `tick` high, only while the dual-mode bit (control reg 0x0 bit 0) is 1 and its run bit is 1 (bit 1 primary, bit 2 secondary). Otherwise it holds its count.
- R3: On a tick while the count is 0xFF, the count loads the reload byte (0x4 primary, 0x7 secondary). The overflow flag is set and the waveform toggles.
- R4: On a tick while the count equals the compare byte (0x5 primary, 0x8 secondary), the compare flag is set and the waveform toggles. If this happens on the same tick as an overflow, both flags are set and the waveform is left unchanged.
- R5: Flags (reg 0x2: bit0 primary overflow, bit1 primary compare, bit2 secondary overflow, bit3 secondary compare) stay set until cleared. A write to reg 0x2 clears each flag whose data bit is 0. A flag raised in the same cycle as the write stays set.
- R6: Pad-config reg 0x1 bit 0 enables pin A, which carries the primary waveform. Bit 1 enables pin B, which carries the secondary waveform. Each pad-enable output follows its bit, and a disabled pin drives 0.
- R7: When an enable bit is written from 0 to 1, the pin starts at the level of the matching polarity bit (bit 2 for A, bit 3 for B) given in that same write.
- R8: Writing a polarity bit while its pin is already enabled does not change the pin.
- R9: With gate-enable (reg 0x0 bit 3) at 1 and pin A disabled, the primary counter does not advance while `gate_pin` equals polarity bit 2. While pin A is enabled, the gate has no effect.
- R10: The secondary counter ignores the gate and the single-shot bit.
- R11: Writing 1 to the single-shot bit (reg 0x0 bit 4, which reads back its state) makes the primary counter run with its run bit at 0. The bit clears itself on the next primary overflow, and the counter then stops.
- R12: If single-shot and primary run are written to 1 together, single-shot still clears at the next overflow, and the counter keeps running.
- R13: Writing a count byte (0x3 primary, 0x6 secondary) loads that count. The load takes priority over a tick in the same cycle, and that tick raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for both counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| gate_pin | input | 1 | External gate for the primary counter |
| pin_a | output | 1 | Primary waveform pad |
| pin_a_oe | output | 1 | Pad enable for pin A |
| pin_b | output | 1 | Secondary waveform pad |
| pin_b_oe | output | 1 | Pad enable for pin B |
| pri_ovf | output | 1 | Primary overflow flag |
| pri_cmp | output | 1 | Primary compare flag |
| sec_ovf | output | 1 | Secondary overflow flag |
| sec_cmp | output | 1 | Secondary compare flag |

## Verification
The assertions check several rules on every cycle:
- the reload at 0xFF;
- that a pin always starts from the polarity latched when it is enabled, and holds between events;
- the gated stall;
- self-clearing of the single-shot bit;
- flag stickiness.

Other behaviours can only be shown by the bench's scenarios, because each needs a particular sequence of writes:
- polarity writes ignored while a pin is enabled;
- the cancelling of the waveform toggle when compare and wrap coincide;
- the gate losing effect once pin A is enabled;
- single-shot combined with run;
- the secondary counter's indifference to gate and single-shot.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam int unsigned AW = 4;

  typedef enum logic [AW-1:0] {
    A_CTRL  = 4'h0,
    A_PADS  = 4'h1,
    A_FLAGS = 4'h2,
    A_PCNT  = 4'h3,
    A_PREL  = 4'h4,
    A_PCMP  = 4'h5,
    A_SCNT  = 4'h6,
    A_SREL  = 4'h7,
    A_SCMP  = 4'h8
  } dt_addr_e;

  localparam int unsigned NCH = 2;
endpackage

// File: rtl/dt8_counter.sv
module dt8_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] reload,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] cnt,
  output logic         ovf_evt,
  output logic         cmp_evt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic step;
  assign step    = adv && !ld_en;
  assign ovf_evt = step && (cnt == MAXV);
  assign cmp_evt = step && (cnt == cmp_val);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (ld_en)   cnt <= ld_val;
    else if (ovf_evt) cnt <= reload;
    else if (step)    cnt <= cnt + 1'b1;
  end

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld_en && cnt == MAXV) |=> (cnt == $past(reload)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !ld_en) |=> $stable(cnt));
endmodule

// File: rtl/dt8_wave.sv
module dt8_wave (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic pol_new,
  input  logic oe,
  input  logic toggle,
  output logic pin,
  output logic pad_en
);
  logic wave_q;
  logic pol_lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave_q  <= 1'b0;
      pol_lat <= 1'b0;
    end else if (arm) begin
      wave_q  <= 1'b0;
      pol_lat <= pol_new;
    end else if (toggle) begin
      wave_q  <= ~wave_q;
    end
  end

  assign pin    = oe && (wave_q ^ pol_lat);
  assign pad_en = oe;

  assert_start_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (pin == $past(pol_new)));

  assert_pin_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !arm && !toggle) |=> (!oe || $stable(pin)));
endmodule

// File: rtl/dt8_regs.sv
module dt8_regs
  import dt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic [W-1:0]  cnt0,
  input  logic [W-1:0]  cnt1,
  input  logic [NCH-1:0] ovf_evt,
  input  logic [NCH-1:0] cmp_evt,
  output logic          dual,
  output logic [NCH-1:0] run,
  output logic          gate_en,
  output logic          ss,
  output logic [NCH-1:0] oe,
  output logic [NCH-1:0] pol,
  output logic [NCH-1:0] arm,
  output logic [NCH-1:0] ld,
  output logic [W-1:0]  rel0,
  output logic [W-1:0]  rel1,
  output logic [W-1:0]  cmp0,
  output logic [W-1:0]  cmp1,
  output logic [3:0]    flags
);
  logic we_ctrl, we_pads, we_flags;
  logic [3:0] fset;

  assign we_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign we_pads  = wr_en && (wr_addr == A_PADS);
  assign we_flags = wr_en && (wr_addr == A_FLAGS);
  assign ld[0]    = wr_en && (wr_addr == A_PCNT);
  assign ld[1]    = wr_en && (wr_addr == A_SCNT);
  assign fset     = {cmp_evt[1], ovf_evt[1], cmp_evt[0], ovf_evt[0]};

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_arm
      assign arm[g] = we_pads && wr_data[g] && !oe[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dual    <= 1'b0;
      run     <= '0;
      gate_en <= 1'b0;
      ss      <= 1'b0;
      oe      <= '0;
      pol     <= '0;
      rel0    <= '0;
      rel1    <= '0;
      cmp0    <= '0;
      cmp1    <= '0;
      flags   <= '0;
    end else begin
      if (we_ctrl) begin
        dual    <= wr_data[0];
        run     <= wr_data[2:1];
        gate_en <= wr_data[3];
      end
      if (we_ctrl && wr_data[4]) ss <= 1'b1;
      else if (ovf_evt[0])       ss <= 1'b0;
      if (we_pads) begin
        oe  <= wr_data[1:0];
        pol <= wr_data[3:2];
      end
      if (wr_en && wr_addr == A_PREL) rel0 <= wr_data;
      if (wr_en && wr_addr == A_SREL) rel1 <= wr_data;
      if (wr_en && wr_addr == A_PCMP) cmp0 <= wr_data;
      if (wr_en && wr_addr == A_SCMP) cmp1 <= wr_data;
      flags <= (we_flags ? (flags & wr_data[3:0]) : flags) | fset;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data = {{(W-5){1'b0}}, ss, gate_en, run, dual};
      A_PADS:  rd_data = {{(W-4){1'b0}}, pol, oe};
      A_FLAGS: rd_data = {{(W-4){1'b0}}, flags};
      A_PCNT:  rd_data = cnt0;
      A_PREL:  rd_data = rel0;
      A_PCMP:  rd_data = cmp0;
      A_SCNT:  rd_data = cnt1;
      A_SREL:  rd_data = rel1;
      A_SCMP:  rd_data = cmp1;
      default: rd_data = '0;
    endcase
  end

  assert_oneshot_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ss && ovf_evt[0] && !(we_ctrl && wr_data[4])) |=> !ss);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_flags |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import dt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          gate_pin,
  output logic          pin_a,
  output logic          pin_a_oe,
  output logic          pin_b,
  output logic          pin_b_oe,
  output logic          pri_ovf,
  output logic          pri_cmp,
  output logic          sec_ovf,
  output logic          sec_cmp
);
  logic          dual, gate_en, ss, stall;
  logic [NCH-1:0] run, oe, pol, arm, ld, adv, ovf_evt, cmp_evt, pin, pad_en;
  logic [W-1:0]  cnt   [NCH];
  logic [W-1:0]  rel   [NCH];
  logic [W-1:0]  cmpv  [NCH];
  logic [3:0]    flags;

  assign stall = gate_en && !oe[0] && (gate_pin == pol[0]);

  dt8_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt0(cnt[0]), .cnt1(cnt[1]), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt),
    .dual(dual), .run(run), .gate_en(gate_en), .ss(ss), .oe(oe),
    .pol(pol), .arm(arm), .ld(ld), .rel0(rel[0]), .rel1(rel[1]),
    .cmp0(cmpv[0]), .cmp1(cmpv[1]), .flags(flags)
  );

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      if (g == 0) begin : g_pri
        assign adv[g] = tick && dual && (run[g] || ss) && !stall;
      end else begin : g_sec
        assign adv[g] = tick && dual && run[g];
      end

      dt8_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .adv(adv[g]), .ld_en(ld[g]),
        .ld_val(wr_data), .reload(rel[g]), .cmp_val(cmpv[g]),
        .cnt(cnt[g]), .ovf_evt(ovf_evt[g]), .cmp_evt(cmp_evt[g])
      );

      dt8_wave u_wave (
        .clk(clk), .rst_n(rst_n), .arm(arm[g]), .pol_new(wr_data[2+g]),
        .oe(oe[g]), .toggle(ovf_evt[g] ^ cmp_evt[g]),
        .pin(pin[g]), .pad_en(pad_en[g])
      );
    end
  endgenerate

  assign pin_a    = pin[0];
  assign pin_a_oe = pad_en[0];
  assign pin_b    = pin[1];
  assign pin_b_oe = pad_en[1];
  assign {sec_cmp, sec_ovf, pri_cmp, pri_ovf} = flags;

  assert_gate_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !oe[0] && gate_pin == pol[0] && !ld[0]) |=> $stable(cnt[0]));

  assert_sec_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dual && run[1] && !ld[1]) |=> (cnt[1] != $past(cnt[1])));
endmodule

// File: tb/dual_reload_timer_bench.sv
module dual_reload_timer_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic tick = 0, wr_en = 0, gate_pin = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic pin_a, pin_a_oe, pin_b, pin_b_oe, pri_ovf, pri_cmp, sec_ovf, sec_cmp;

  int total = 0, bad = 0;
  bit done = 0;

  int    q_sel[$];
  int    q_exp[$];
  string q_tag[$];

  always #4 clk = ~clk;

  dual_reload_timer u_dual_reload_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .gate_pin(gate_pin), .pin_a(pin_a), .pin_a_oe(pin_a_oe), .pin_b(pin_b),
    .pin_b_oe(pin_b_oe), .pri_ovf(pri_ovf), .pri_cmp(pri_cmp),
    .sec_ovf(sec_ovf), .sec_cmp(sec_cmp)
  );

  // monitor: compares queued expectations shortly after the falling edge
  always begin
    @(negedge clk);
    #1;
    while (q_sel.size() > 0) begin
      int s, e, a;
      string t;
      s = q_sel.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      if (s == 0)      a = int'(rd_data);
      else if (s == 1) a = int'({pin_b_oe, pin_b, pin_a_oe, pin_a});
      else             a = int'({sec_cmp, sec_ovf, pri_cmp, pri_ovf});
      total++;
      if (a != e) begin
        bad++;
        $display("FAIL %s actual=%0h expected=%0h", t, a, e);
      end
    end
  end

  task automatic wr(input logic [3:0] ad, input logic [7:0] d);
    wr_en = 1; wr_addr = ad; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic ticks(input int n);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic chk_rd(input logic [3:0] ad, input int e, input string t);
    rd_addr = ad;
    q_sel.push_back(0); q_exp.push_back(e); q_tag.push_back(t);
    @(negedge clk);
  endtask

  task automatic chk_pins(input int e, input string t);
    q_sel.push_back(1); q_exp.push_back(e); q_tag.push_back(t);
    @(negedge clk);
  endtask

  task automatic chk_flags(input int e, input string t);
    q_sel.push_back(2); q_exp.push_back(e); q_tag.push_back(t);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_rd(4'h0, 0, "R1 ctrl");
    chk_rd(4'h3, 0, "R1 count");
    chk_pins(0, "R1 pins");
    chk_flags(0, "R1 flags");

    wr(4'h4, 8'hFC);
    wr(4'h5, 8'hFD);
    wr(4'h3, 8'hFA);
    chk_rd(4'h3, 8'hFA, "R13 count load");
    wr(4'h0, 8'h03);
    ticks(1);
    chk_rd(4'h3, 8'hFB, "R2 increment");
    wr(4'h0, 8'h02);
    ticks(3);
    chk_rd(4'h3, 8'hFB, "R2 dual off holds");
    wr(4'h0, 8'h03);

    wr(4'h1, 8'h05);
    chk_pins(4'b0011, "R7 start at polarity");
    ticks(2);
    chk_pins(4'b0011, "R7 no event yet");
    ticks(1);
    chk_pins(4'b0010, "R4 compare toggles");
    chk_flags(4'b0010, "R4 compare flag");
    wr(4'h1, 8'h01);
    chk_pins(4'b0010, "R8 polarity ignored while enabled");
    ticks(2);
    chk_pins(4'b0011, "R3 overflow toggles");
    chk_flags(4'b0011, "R3 overflow flag");
    chk_rd(4'h3, 8'hFC, "R3 reload");
    wr(4'h2, 8'h01);
    chk_flags(4'b0001, "R5 selective clear");
    wr(4'h2, 8'h00);

    wr(4'h5, 8'hFF);
    ticks(4);
    chk_pins(4'b0011, "R4 coincident events cancel");
    chk_flags(4'b0011, "R4 both flags");
    wr(4'h2, 8'h00);

    wr(4'h0, 8'h01);
    ticks(2);
    chk_rd(4'h3, 8'hFC, "R2 run off holds");
    wr(4'h0, 8'h11);
    chk_rd(4'h0, 8'h11, "R11 single shot armed");
    ticks(6);
    chk_rd(4'h3, 8'hFC, "R11 stops after wrap");
    chk_rd(4'h0, 8'h01, "R11 self clear");
    wr(4'h0, 8'h13);
    ticks(6);
    chk_rd(4'h0, 8'h03, "R12 single shot cleared");
    chk_rd(4'h3, 8'hFE, "R12 keeps running");
    wr(4'h0, 8'h01);

    wr(4'h1, 8'h00);
    wr(4'h0, 8'h0B);
    gate_pin = 0;
    ticks(3);
    chk_rd(4'h3, 8'hFE, "R9 gated stall");
    gate_pin = 1;
    ticks(1);
    chk_rd(4'h3, 8'hFF, "R9 gate open");
    gate_pin = 0;
    wr(4'h1, 8'h01);
    ticks(1);
    chk_rd(4'h3, 8'hFC, "R9 gate ignored with pin A enabled");
    wr(4'h1, 8'h04);
    gate_pin = 1;
    ticks(2);
    chk_rd(4'h3, 8'hFC, "R9 stall at high polarity");
    gate_pin = 0;
    ticks(1);
    chk_rd(4'h3, 8'hFD, "R9 open at high polarity");

    wr(4'h0, 8'h0D);
    wr(4'h2, 8'h00);
    wr(4'h7, 8'h10);
    wr(4'h8, 8'h11);
    wr(4'h6, 8'hFE);
    wr(4'h1, 8'h02);
    chk_pins(4'b1000, "R6 pin B enabled, A off");
    ticks(2);
    chk_pins(4'b1100, "R10 secondary wraps ungated");
    ticks(2);
    chk_pins(4'b1000, "R6 secondary compare toggles");
    chk_flags(4'b1100, "R5 secondary flags");
    chk_rd(4'h6, 8'h12, "R10 secondary count");
    chk_rd(4'h3, 8'hFD, "R2 primary held");
    wr(4'h0, 8'h11);
    ticks(2);
    chk_rd(4'h6, 8'h12, "R10 single shot not on secondary");
    chk_rd(4'h3, 8'hFF, "R11 primary single shot");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule